// File: doc/BRIEF.md
# Byte-Wide NOR Flash Command Emulator

This block is a synthesizable behavioural stand-in for a byte-wide parallel NOR flash. It sits behind an asynchronous SRAM-style bus (select, write strobe and read strobe, all active low) and samples that bus with a fast system clock. Command writes are decoded as unlock sequences that start an embedded byte program, a sector erase or a whole-array erase. Each operation runs for a configurable number of clocks, so that simulation stays short. A ready output is low for as long as the operation runs.

While an operation runs, a read does not return array data. It returns a status byte: a polling bit, a toggle bit that inverts on every status read, and a second toggle bit that inverts only for reads inside the sector being erased. A separate command-reset input aborts any running operation and puts the decoder back into array-read mode. The array is a parameterised memory split into `1 << SECT_W` equal sectors. The sector number is the top `SECT_W` address bits.

Top module: `nor_flash_emu`

## Requirements
- R1: After system reset, `not_busy` is 1 and `bus_rd_oe` is 0 until a read access begins.
- R2: With no operation running, a read access (select and read strobe low, write strobe high) drives `bus_rd_oe` high and returns the stored byte at `bus_addr` on `bus_rdata`.
- R3: The write sequence 555h/AAh, 2AAh/55h, 555h/A0h, then target/value programs one byte. The stored byte becomes old AND value. Command addresses compare only the low 11 address bits. A write is taken on the rising edge of the write strobe while select is low.
- R4: A program holds `not_busy` low for exactly `PGM_CYCLES` clock cycles.
- R5: The sequence 555h/AAh, 2AAh/55h, 555h/80h, 555h/AAh, 2AAh/55h, then any address with 30h sets every byte of that address's sector to FFh. Other sectors are left unchanged. `not_busy` stays low for at least `ERS_CYCLES` cycles.
- R6: The same erase setup ended by 555h/10h instead sets every byte of the array to FFh.
- R7: A write that does not match the next expected step sends the decoder back to read mode. The later steps of the broken sequence then start nothing.
- R8: A status read during a program returns bit 7 as the complement of bit 7 of the value being programmed. During an erase, bit 7 is 0.
- R9: During an operation, bit 6 inverts on every consecutive status read. After completion, reads return array data.
- R10: In the status byte, bit 2 inverts only on reads inside the sector being erased (any sector for a whole-array erase) and otherwise holds its value. Bit 3 is 1 during an erase and 0 during a program. Bits 5, 4, 1 and 0 are 0.
- R11: Writes issued while an operation runs are ignored.
- R12: Driving `cmd_rst_n` low aborts any running operation (`not_busy` returns to 1), clears a partly entered sequence and restores array-read mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Asynchronous active-low system reset, released synchronously |
| cmd_rst_n | input | 1 | Active-low command reset / abort, asynchronous, synchronised inside |
| bus_sel_n | input | 1 | Active-low device select |
| bus_wr_n | input | 1 | Active-low write strobe; a write is taken on its rising edge |
| bus_rd_n | input | 1 | Active-low read strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 8 | Write data / command byte |
| bus_rdata | output | 8 | Array byte or status byte, captured at the start of each read access |
| bus_rd_oe | output | 1 | High while a read access is active (output-enable for a bus driver) |
| not_busy | output | 1 | Low while a program or erase runs |

## Verification
A decoder stuck in a wrong sequence state shows up at the ports on the first command that follows. An extra or missing step either starts an operation that should not start, visible on `not_busy` within three clocks of the final write strobe, or leaves the array byte unchanged on the next read. A wrong engine state shows in the length of the busy window, counted to the cycle for programs. It also shows in the contents of a full-array read sweep after each erase. Toggle or polling state errors appear in the status bytes of two back-to-back reads during the same operation.

// File: rtl/nor_pkg.sv
package nor_pkg;

  localparam int CMD_AW = 11;

  localparam logic [CMD_AW-1:0] ADR_FIRST  = 11'h555;
  localparam logic [CMD_AW-1:0] ADR_SECOND = 11'h2AA;

  localparam logic [7:0] KEY_FIRST   = 8'hAA;
  localparam logic [7:0] KEY_SECOND  = 8'h55;
  localparam logic [7:0] OP_PROGRAM  = 8'hA0;
  localparam logic [7:0] OP_ERS_SET  = 8'h80;
  localparam logic [7:0] OP_ERS_SECT = 8'h30;
  localparam logic [7:0] OP_ERS_ALL  = 8'h10;

  typedef enum logic [2:0] {
    ST_READ,
    ST_KEY1,
    ST_KEY2,
    ST_PGM_ARM,
    ST_ERS_ARM,
    ST_ERS_KEY1,
    ST_ERS_KEY2
  } cmd_state_t;

endpackage

// File: rtl/nor_bus_sync.sv
module nor_bus_sync #(
  parameter int              W       = 4,
  parameter int              STAGES  = 2,
  parameter logic [W-1:0]    RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);

  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= RST_VAL;
    end else begin
      stage_q[0] <= async_i;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/nor_cmd_decode.sv
module nor_cmd_decode
  import nor_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              abort,
  input  logic              wr_evt,
  input  logic              busy,
  input  logic [CMD_AW-1:0] cmd_addr,
  input  logic [7:0]        cmd_data,
  output logic              start_pgm,
  output logic              start_ers,
  output logic              ers_all
);

  cmd_state_t st_q, st_d;
  logic       wr_ok, at_first, at_second;

  assign wr_ok     = wr_evt && !busy;
  assign at_first  = (cmd_addr == ADR_FIRST);
  assign at_second = (cmd_addr == ADR_SECOND);

  always_comb begin
    st_d      = st_q;
    start_pgm = 1'b0;
    start_ers = 1'b0;
    ers_all   = 1'b0;
    if (abort) begin
      st_d = ST_READ;
    end else if (wr_ok) begin
      st_d = ST_READ;
      unique case (st_q)
        ST_READ:     if (at_first && cmd_data == KEY_FIRST) st_d = ST_KEY1;
        ST_KEY1:     if (at_second && cmd_data == KEY_SECOND) st_d = ST_KEY2;
        ST_KEY2: begin
          if (at_first && cmd_data == OP_PROGRAM)      st_d = ST_PGM_ARM;
          else if (at_first && cmd_data == OP_ERS_SET) st_d = ST_ERS_ARM;
        end
        ST_PGM_ARM:  start_pgm = 1'b1;
        ST_ERS_ARM:  if (at_first && cmd_data == KEY_FIRST) st_d = ST_ERS_KEY1;
        ST_ERS_KEY1: if (at_second && cmd_data == KEY_SECOND) st_d = ST_ERS_KEY2;
        ST_ERS_KEY2: begin
          if (cmd_data == OP_ERS_SECT) begin
            start_ers = 1'b1;
          end else if (at_first && cmd_data == OP_ERS_ALL) begin
            start_ers = 1'b1;
            ers_all   = 1'b1;
          end
        end
        default:     st_d = ST_READ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_READ;
    else        st_q <= st_d;
  end

endmodule

// File: rtl/nor_embedded_engine.sv
module nor_embedded_engine #(
  parameter int ADDR_W     = 11,
  parameter int SECT_W     = 2,
  parameter int PGM_CYCLES = 8,
  parameter int ERS_CYCLES = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              abort,
  input  logic              start_pgm,
  input  logic              start_ers,
  input  logic              ers_all,
  input  logic [ADDR_W-1:0] op_addr,
  input  logic [7:0]        op_data,
  output logic              busy_o,
  output logic              erase_o,
  output logic              all_o,
  output logic [SECT_W-1:0] sector_o,
  output logic              pgm_bit7_o,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  output logic              mem_and
);

  localparam int OFF_W = ADDR_W - SECT_W;
  localparam int MAXC  = (PGM_CYCLES > ERS_CYCLES) ? PGM_CYCLES : ERS_CYCLES;
  localparam int CW    = $clog2(MAXC + 1);
  localparam logic [CW-1:0] PGM_LOAD = CW'(PGM_CYCLES - 1);
  localparam logic [CW-1:0] ERS_LOAD = CW'(ERS_CYCLES - 1);

  logic              busy_q, busy_d;
  logic              erase_q, erase_d;
  logic              all_q, all_d;
  logic              done_q, done_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [7:0]        data_q, data_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic [ADDR_W-1:0] ptr_q, ptr_d;
  logic              walk_last;

  assign walk_last = all_q ? (&ptr_q) : (&ptr_q[OFF_W-1:0]);

  always_comb begin
    busy_d  = busy_q;
    erase_d = erase_q;
    all_d   = all_q;
    done_d  = done_q;
    addr_d  = addr_q;
    data_d  = data_q;
    cnt_d   = cnt_q;
    ptr_d   = ptr_q;
    if (abort) begin
      busy_d = 1'b0;
      done_d = 1'b0;
    end else if (!busy_q) begin
      if (start_pgm) begin
        busy_d  = 1'b1;
        erase_d = 1'b0;
        all_d   = 1'b0;
        addr_d  = op_addr;
        data_d  = op_data;
        cnt_d   = PGM_LOAD;
      end else if (start_ers) begin
        busy_d  = 1'b1;
        erase_d = 1'b1;
        all_d   = ers_all;
        addr_d  = op_addr;
        data_d  = 8'hFF;
        cnt_d   = ERS_LOAD;
        ptr_d   = '0;
        done_d  = 1'b0;
      end
    end else begin
      if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
      if (erase_q && !done_q) begin
        ptr_d = ptr_q + 1'b1;
        if (walk_last) done_d = 1'b1;
      end
      if (cnt_q == '0 && (!erase_q || done_q)) busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      erase_q <= 1'b0;
      all_q   <= 1'b0;
      done_q  <= 1'b0;
      addr_q  <= '0;
      data_q  <= '0;
      cnt_q   <= '0;
      ptr_q   <= '0;
    end else begin
      busy_q  <= busy_d;
      erase_q <= erase_d;
      all_q   <= all_d;
      done_q  <= done_d;
      addr_q  <= addr_d;
      data_q  <= data_d;
      cnt_q   <= cnt_d;
      ptr_q   <= ptr_d;
    end
  end

  always_comb begin
    mem_we    = busy_q && !abort && (erase_q ? !done_q : (cnt_q == '0));
    mem_wdata = data_q;
    mem_and   = !erase_q;
    if (!erase_q)   mem_addr = addr_q;
    else if (all_q) mem_addr = ptr_q;
    else            mem_addr = {addr_q[ADDR_W-1:OFF_W], ptr_q[OFF_W-1:0]};
  end

  assign busy_o     = busy_q;
  assign erase_o    = erase_q;
  assign all_o      = all_q;
  assign sector_o   = addr_q[ADDR_W-1:OFF_W];
  assign pgm_bit7_o = data_q[7];

endmodule

// File: rtl/nor_array.sv
module nor_array #(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              we,
  input  logic              and_mode,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [7:0]        wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [7:0]        rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= and_mode ? (cells[waddr] & wdata) : wdata;
  end

  assign rdata = cells[raddr];

endmodule

// File: rtl/nor_read_port.sv
module nor_read_port #(
  parameter int SECT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              abort,
  input  logic              rd_evt,
  input  logic [SECT_W-1:0] rd_sector,
  input  logic              busy,
  input  logic              erase,
  input  logic              ers_all,
  input  logic [SECT_W-1:0] op_sector,
  input  logic              pgm_bit7,
  input  logic [7:0]        arr_data,
  output logic [7:0]        rdata_o
);

  logic       t6_q, t6_d;
  logic       t2_q, t2_d;
  logic [7:0] rdata_q, rdata_d;
  logic       hit;
  logic [7:0] status;

  assign hit    = erase && (ers_all || rd_sector == op_sector);
  assign status = {(erase ? 1'b0 : ~pgm_bit7), t6_q, 2'b00, erase, t2_q, 2'b00};

  always_comb begin
    t6_d    = t6_q;
    t2_d    = t2_q;
    rdata_d = rdata_q;
    if (rd_evt) begin
      rdata_d = busy ? status : arr_data;
      if (busy)        t6_d = ~t6_q;
      if (busy && hit) t2_d = ~t2_q;
    end
    if (abort) begin
      t6_d = 1'b0;
      t2_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t6_q    <= 1'b0;
      t2_q    <= 1'b0;
      rdata_q <= '0;
    end else begin
      t6_q    <= t6_d;
      t2_q    <= t2_d;
      rdata_q <= rdata_d;
    end
  end

  assign rdata_o = rdata_q;

endmodule

// File: rtl/nor_flash_emu.sv
module nor_flash_emu
  import nor_pkg::*;
#(
  parameter int ADDR_W      = 11,
  parameter int SECT_W      = 2,
  parameter int PGM_CYCLES  = 8,
  parameter int ERS_CYCLES  = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_rst_n,
  input  logic              bus_sel_n,
  input  logic              bus_wr_n,
  input  logic              bus_rd_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              bus_rd_oe,
  output logic              not_busy
);

  localparam int OFF_W = ADDR_W - SECT_W;

  logic [1:0]        rst_pipe_q;
  logic              sys_rst_n;
  logic [3:0]        strobe_s;
  logic              crst_s, sel_s, wr_s, rd_s;
  logic              wr_q, rd_q;
  logic              wr_evt, rd_act, rd_evt, cmd_abort;
  logic              start_pgm, start_ers, ers_all;
  logic              eng_busy, eng_erase, eng_all, eng_bit7;
  logic [SECT_W-1:0] eng_sector;
  logic              mem_we, mem_and;
  logic [ADDR_W-1:0] mem_addr;
  logic [7:0]        mem_wdata, arr_rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign sys_rst_n = rst_pipe_q[1];

  nor_bus_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'hF)) i_sync (
    .clk     (clk),
    .rst_n   (sys_rst_n),
    .async_i ({cmd_rst_n, bus_sel_n, bus_wr_n, bus_rd_n}),
    .sync_o  (strobe_s)
  );
  assign {crst_s, sel_s, wr_s, rd_s} = strobe_s;

  always_ff @(posedge clk or negedge sys_rst_n) begin
    if (!sys_rst_n) begin
      wr_q <= 1'b1;
      rd_q <= 1'b0;
    end else begin
      wr_q <= wr_s;
      rd_q <= rd_act;
    end
  end

  assign cmd_abort = !crst_s;
  assign wr_evt    = wr_s && !wr_q && !sel_s;
  assign rd_act    = !sel_s && !rd_s && wr_s;
  assign rd_evt    = rd_act && !rd_q;

  nor_cmd_decode i_dec (
    .clk       (clk),
    .rst_n     (sys_rst_n),
    .abort     (cmd_abort),
    .wr_evt    (wr_evt),
    .busy      (eng_busy),
    .cmd_addr  (bus_addr[CMD_AW-1:0]),
    .cmd_data  (bus_wdata),
    .start_pgm (start_pgm),
    .start_ers (start_ers),
    .ers_all   (ers_all)
  );

  nor_embedded_engine #(
    .ADDR_W(ADDR_W), .SECT_W(SECT_W),
    .PGM_CYCLES(PGM_CYCLES), .ERS_CYCLES(ERS_CYCLES)
  ) i_eng (
    .clk        (clk),
    .rst_n      (sys_rst_n),
    .abort      (cmd_abort),
    .start_pgm  (start_pgm),
    .start_ers  (start_ers),
    .ers_all    (ers_all),
    .op_addr    (bus_addr),
    .op_data    (bus_wdata),
    .busy_o     (eng_busy),
    .erase_o    (eng_erase),
    .all_o      (eng_all),
    .sector_o   (eng_sector),
    .pgm_bit7_o (eng_bit7),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_and    (mem_and)
  );

  nor_array #(.ADDR_W(ADDR_W)) i_arr (
    .clk      (clk),
    .we       (mem_we),
    .and_mode (mem_and),
    .waddr    (mem_addr),
    .wdata    (mem_wdata),
    .raddr    (bus_addr),
    .rdata    (arr_rdata)
  );

  nor_read_port #(.SECT_W(SECT_W)) i_rdp (
    .clk       (clk),
    .rst_n     (sys_rst_n),
    .abort     (cmd_abort),
    .rd_evt    (rd_evt),
    .rd_sector (bus_addr[ADDR_W-1:OFF_W]),
    .busy      (eng_busy),
    .erase     (eng_erase),
    .ers_all   (eng_all),
    .op_sector (eng_sector),
    .pgm_bit7  (eng_bit7),
    .arr_data  (arr_rdata),
    .rdata_o   (bus_rdata)
  );

  assign bus_rd_oe = rd_act;
  assign not_busy  = !eng_busy;

endmodule

// File: rtl/nor_flash_emu_chk.sv
module nor_flash_emu_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       abort,
  input logic       start_pgm,
  input logic       start_ers,
  input logic       not_busy,
  input logic       rd_evt,
  input logic       erase,
  input logic       pgm_bit7,
  input logic [7:0] rdata
);

  AST_START_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (start_pgm || start_ers) |-> not_busy);  // R11

  AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
    ((start_pgm || start_ers) && !abort) |=> !not_busy);  // R3

  AST_BUSY_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(not_busy) |-> $past(start_pgm || start_ers));  // R4

  AST_ERASE_POLL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_evt && !not_busy && erase) |=> !rdata[7]);  // R8

  AST_PGM_POLL_INV: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_evt && !not_busy && !erase) |=> (rdata[7] == !$past(pgm_bit7)));  // R8

  AST_STATUS_ZERO_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_evt && !not_busy) |=> (rdata[5:4] == 2'b00 && rdata[1:0] == 2'b00));  // R10

  AST_ABORT_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> not_busy);  // R12

endmodule

bind nor_flash_emu nor_flash_emu_chk i_chk (
  .clk       (clk),
  .rst_n     (sys_rst_n),
  .abort     (cmd_abort),
  .start_pgm (start_pgm),
  .start_ers (start_ers),
  .not_busy  (not_busy),
  .rd_evt    (rd_evt),
  .erase     (eng_erase),
  .pgm_bit7  (eng_bit7),
  .rdata     (bus_rdata)
);

// File: tb/test_nor_flash_emu.sv
module test_nor_flash_emu;

  localparam int CLK_PERIOD = 10;
  localparam int AW   = 11;
  localparam int SW   = 2;
  localparam int PGM  = 60;
  localparam int ERS  = 700;
  localparam int NB   = 1 << AW;
  localparam int SECB = 1 << (AW - SW);

  logic          clk = 1'b0;
  logic          rst_n, cmd_rst_n, bus_sel_n, bus_wr_n, bus_rd_n;
  logic [AW-1:0] bus_addr;
  logic [7:0]    bus_wdata, bus_rdata;
  logic          bus_rd_oe, not_busy;

  int   errors = 0;
  int   checks = 0;
  int   busy_cycles = 0;
  bit   oe_seen;
  logic [7:0] model [NB];

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) if (not_busy === 1'b0) busy_cycles++;

  nor_flash_emu #(.ADDR_W(AW), .SECT_W(SW), .PGM_CYCLES(PGM), .ERS_CYCLES(ERS)) i_nor_flash_emu (
    .clk(clk), .rst_n(rst_n), .cmd_rst_n(cmd_rst_n),
    .bus_sel_n(bus_sel_n), .bus_wr_n(bus_wr_n), .bus_rd_n(bus_rd_n),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_rd_oe(bus_rd_oe), .not_busy(not_busy)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_sel_n = 1'b0; bus_wr_n = 1'b0;
    repeat (3) @(negedge clk);
    bus_wr_n = 1'b1;
    repeat (4) @(negedge clk);
    bus_sel_n = 1'b1;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_sel_n = 1'b0; bus_rd_n = 1'b0;
    repeat (5) @(negedge clk);
    d = bus_rdata; oe_seen = bus_rd_oe;
    bus_sel_n = 1'b1; bus_rd_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic wait_ready(input string req);
    int n = 0;
    while (not_busy !== 1'b1 && n < 5000) begin @(negedge clk); n++; end
    chk(not_busy === 1'b1, req, {31'd0, not_busy}, 1);
  endtask

  task automatic unlock();
    wr(11'h555, 8'hAA); wr(11'h2AA, 8'h55);
  endtask

  task automatic erase_setup();
    unlock(); wr(11'h555, 8'h80); unlock();
  endtask

  task automatic prog(input logic [AW-1:0] a, input logic [7:0] d);
    unlock(); wr(11'h555, 8'hA0); wr(a, d);
    model[a] = model[a] & d;
  endtask

  task automatic sweep(input string req);
    logic [7:0] v;
    for (int i = 0; i < NB; i++) begin
      rd(AW'(i), v);
      chk(v === model[i], req, v, model[i]);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] s0, s1, s2, s3, v;
    rst_n = 1'b0; cmd_rst_n = 1'b1; bus_sel_n = 1'b1; bus_wr_n = 1'b1; bus_rd_n = 1'b1;
    bus_addr = '0; bus_wdata = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(not_busy === 1'b1, "R1 idle after reset", {31'd0, not_busy}, 1);
    chk(bus_rd_oe === 1'b0, "R1 no output enable", {31'd0, bus_rd_oe}, 0);

    // R6 whole-array erase
    erase_setup(); wr(11'h555, 8'h10);
    chk(not_busy === 1'b0, "R6 busy after chip erase", {31'd0, not_busy}, 0);
    wait_ready("R6 chip erase finishes");
    for (int i = 0; i < NB; i++) model[i] = 8'hFF;
    sweep("R6 all bytes FF");
    chk(oe_seen === 1'b1, "R2 output enable during read", {31'd0, oe_seen}, 1);

    // R4 R8 R9 R10 program status
    busy_cycles = 0;
    prog(11'h007, 8'h35);
    rd(11'h007, s0); rd(11'h007, s1); rd(11'h007, s2);
    chk(s0[7] === 1'b1 && s1[7] === 1'b1, "R8 program polling bit", {s0, s1}, 16'h8080);
    chk(s0[6] !== s1[6] && s1[6] !== s2[6], "R9 bit6 toggles", {s0, s1, s2}, 0);
    chk(s0[2] === s1[2] && s1[2] === s2[2], "R10 bit2 stable in program", {s0, s1, s2}, 0);
    chk(s0[3] === 1'b0, "R10 bit3 zero in program", s0, 0);
    chk((s0 & 8'h33) === 8'h00 && (s1 & 8'h33) === 8'h00, "R10 zero bits", {s0, s1}, 0);
    wait_ready("R4 program finishes");
    chk(busy_cycles == PGM, "R4 program busy length", busy_cycles, PGM);
    rd(11'h007, v);
    chk(v === 8'h35, "R9 array data after completion", v, 8'h35);

    // R3 pattern sweep, twice for AND behaviour
    for (int p = 0; p < 2; p++) begin
      for (int i = 0; i < 16; i++) begin
        prog(AW'((i * 131 + 9) % NB), (p == 0) ? 8'(i * 37 + 5) : 8'(i * 91 + 200));
        wait_ready("R3 program finishes");
      end
    end
    for (int i = 0; i < 16; i++) begin
      rd(AW'((i * 131 + 9) % NB), v);
      chk(v === model[(i * 131 + 9) % NB], "R3 program result", v, model[(i * 131 + 9) % NB]);
    end

    // R5 R8 R10 R11 sector erase of sector 1
    busy_cycles = 0;
    erase_setup(); wr(11'h2A3, 8'h30);
    rd(11'd600, s0); rd(11'd600, s1);
    rd(11'd1800, s2); rd(11'd1800, s3);
    chk(s0[7] === 1'b0 && s1[7] === 1'b0, "R8 erase polling bit", {s0, s1}, 0);
    chk(s0[2] !== s1[2], "R10 bit2 toggles in erased sector", {s0, s1}, 0);
    chk(s2[2] === s3[2], "R10 bit2 holds outside erased sector", {s2, s3}, 0);
    chk(s0[3] === 1'b1, "R10 bit3 set in erase", s0, 8'h08);
    chk(s0[6] !== s1[6] && s2[6] !== s3[6], "R9 bit6 toggles in erase", {s0, s1, s2, s3}, 0);
    unlock(); wr(11'h555, 8'hA0); wr(11'd1900, 8'h00);
    wait_ready("R5 sector erase finishes");
    chk(busy_cycles >= ERS, "R5 erase busy length", busy_cycles, ERS);
    for (int i = SECB; i < 2 * SECB; i++) model[i] = 8'hFF;
    rd(11'd1900, v);
    chk(v === model[1900], "R11 write during busy ignored", v, model[1900]);
    sweep("R5 sector erase contents");

    // R7 broken sequences
    unlock(); wr(11'h2AA, 8'h00);
    wr(11'h555, 8'hA0); wr(11'd40, 8'h00);
    repeat (4) @(negedge clk);
    chk(not_busy === 1'b1, "R7 no start after wrong data", {31'd0, not_busy}, 1);
    rd(11'd40, v);
    chk(v === model[40], "R7 byte unchanged", v, model[40]);
    wr(11'h555, 8'hAA); wr(11'h2AB, 8'h55);
    wr(11'h555, 8'hA0); wr(11'd41, 8'h00);
    rd(11'd41, v);
    chk(v === model[41], "R7 wrong address ignored", v, model[41]);

    // R12 command reset
    unlock();
    @(negedge clk); cmd_rst_n = 1'b0; repeat (4) @(negedge clk); cmd_rst_n = 1'b1; repeat (4) @(negedge clk);
    wr(11'h555, 8'hA0); wr(11'd42, 8'h00);
    rd(11'd42, v);
    chk(v === model[42], "R12 partial sequence cleared", v, model[42]);
    erase_setup(); wr(11'd1600, 8'h30);
    repeat (20) @(negedge clk);
    chk(not_busy === 1'b0, "R12 erase running before abort", {31'd0, not_busy}, 0);
    cmd_rst_n = 1'b0; repeat (4) @(negedge clk); cmd_rst_n = 1'b1; repeat (4) @(negedge clk);
    chk(not_busy === 1'b1, "R12 abort releases ready", {31'd0, not_busy}, 1);
    rd(11'd100, v);
    chk(v === model[100], "R12 array read after abort", v, model[100]);
    prog(11'd100, 8'h0F);
    wait_ready("R12 program after abort");
    rd(11'd100, v);
    chk(v === model[100], "R12 program after abort result", v, model[100]);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule